// File: doc/BRIEF.md
# Add-or-Subtract-Three Unit with Cross-Checked Bit Realizations

This block is purely combinational. It takes a 4-bit unsigned value and a mode bit. When the mode bit is low, the result is the value plus three. When it is high, the result is the value minus three. The result appears on the outputs in the same cycle as the inputs, with no register on the path.

The main result comes from a ripple-carry adder. A four-wide 2:1 selector picks the constant operand that feeds it: 0011 for plus, or its two's complement 1101 for minus. The final carry is dropped. The block also builds a second copy of the result. In this copy, each bit has its own fixed gate-level style:
- The top bit uses two levels of NAND gates over true and complemented literals.
- Bit 2 uses a minterm decoder built from a 2-to-4 decoder that enables four 3-to-8 decoders, followed by an OR over the chosen lines.
- Bit 1 uses one 8:1 selector steered by the mode bit and the upper two value bits.
- Bit 0 uses a 2-to-4 decoder on the low two value bits. Its outputs enable four drivers onto one merged line.

Both copies are exposed at the ports, so the second copy can be compared with the first. The truth-table index is {mode, value[3:0]}, with the mode bit most significant.

Some input pairs would give a result above 15 or below 0: plus with a value of 13 to 15, and minus with a value of 0 to 2. These pairs never occur, and both outputs are unspecified for them. There is no data stream and no clock, so the ports are plain and there is no back-pressure.

Top module: `addsub3_unit`

## Requirements
- R1: With sub_mode = 0 and n_in in 0..12, sum_out equals n_in + 3.
- R2: With sub_mode = 1 and n_in in 3..15, sum_out equals n_in - 3.
- R3: Both outputs follow a change of inputs with no clock edge in between. The block holds no state.
- R4: alt_out[3] equals sum_out[3] for every legal input pair. It is built as two levels of NAND gates.
- R5: alt_out[2] equals sum_out[2] for every legal input pair. It is built as an OR of the lines of a 32-line decoder indexed by {sub_mode, n_in}. The decoder is made of a 2-to-4 decoder on {sub_mode, n_in[3]} that enables four 3-to-8 decoders on n_in[2:0].
- R6: alt_out[1] equals sum_out[1] for every legal input pair. It is built with one 8:1 selector on {sub_mode, n_in[3], n_in[2]}, whose data inputs depend only on n_in[1:0].
- R7: alt_out[0] equals sum_out[0] for every legal input pair. It is built from a 2-to-4 decoder on n_in[1:0] that enables exactly one of four drivers onto a merged line.
- R8: For every legal input pair, sum_out[0] and alt_out[0] are the inverse of n_in[0].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| n_in | input | 4 | Unsigned operand |
| sub_mode | input | 1 | 0 selects plus three, 1 selects minus three |
| sum_out | output | 4 | Result from the selector-plus-adder path |
| alt_out | output | 4 | Result rebuilt one bit at a time in the fixed structural styles |

## Verification
The bench goes after the edges of the legal range: plus at values 0 and 12, minus at values 3 and 15. A wrong operand constant or a carry that is not dropped would show up there as a wrapped or off-by-one result. It also targets values where the low two bits roll over, such as 4, 7, 8 and 11. A swapped data input on the bit-1 selector, or a missing minterm in the bit-2 OR, would flip only that one bit of alt_out. Random legal pairs then cover the remaining entries of the table, including every lane of the bit-0 decoder. A driver wired to the wrong decoder line would break the rule that bit 0 inverts the input's low bit.

// File: rtl/addsub3_pkg.sv
package addsub3_pkg;
  localparam int unsigned OPW = 4;
  localparam int unsigned IDXW = OPW + 1;
  localparam int unsigned LINES = 1 << IDXW;
  localparam logic [OPW-1:0] K_PLUS = 4'b0011;
  localparam logic [OPW-1:0] K_MINUS = 4'b1101;
  // Lines {mode,n} where result bit 2 is set: 1-4, 9-12, 23-26, 31
  localparam logic [LINES-1:0] BIT2_LINES = 32'h8780_1E1E;
endpackage

// File: rtl/a3_operand_adder.sv
module a3_operand_adder
  import addsub3_pkg::*;
#(
  parameter int unsigned W = OPW
) (
  input  logic [W-1:0] a_in,
  input  logic         sub_mode,
  output logic [W-1:0] sum
);
  logic [W-1:0] operand;
  logic [W-1:0] carry;

  // four-wide 2:1 selector for the constant
  genvar i;
  generate
    for (i = 0; i < W; i++) begin : g_sel
      assign operand[i] = sub_mode ? K_MINUS[i] : K_PLUS[i];
    end
  endgenerate

  assign carry[0] = 1'b0;
  generate
    for (i = 0; i < W; i++) begin : g_fa
      assign sum[i] = a_in[i] ^ operand[i] ^ carry[i];
      if (i < W - 1) begin : g_c
        assign carry[i+1] = (a_in[i] & operand[i]) | (carry[i] & (a_in[i] ^ operand[i]));
      end
    end
  endgenerate
endmodule

// File: rtl/a3_dec2to4.sv
module a3_dec2to4 (
  input  logic       en,
  input  logic [1:0] sel,
  output logic [3:0] y
);
  genvar i;
  generate
    for (i = 0; i < 4; i++) begin : g_y
      assign y[i] = en & (sel == 2'(i));
    end
  endgenerate
endmodule

// File: rtl/a3_dec3to8.sv
module a3_dec3to8 (
  input  logic       en,
  input  logic [2:0] sel,
  output logic [7:0] y
);
  genvar i;
  generate
    for (i = 0; i < 8; i++) begin : g_y
      assign y[i] = en & (sel == 3'(i));
    end
  endgenerate
endmodule

// File: rtl/a3_bit3_nand.sv
module a3_bit3_nand (
  input  logic       k_t, k_c,
  input  logic [3:0] n_t, n_c,
  output logic       m3
);
  // terms: K'N3, K'N2N0, K'N2N1, N3N2, K N3N1N0
  logic [4:0] p;
  assign p[0] = ~(k_c & n_t[3]);
  assign p[1] = ~(k_c & n_t[2] & n_t[0]);
  assign p[2] = ~(k_c & n_t[2] & n_t[1]);
  assign p[3] = ~(n_t[3] & n_t[2]);
  assign p[4] = ~(k_t & n_t[3] & n_t[1] & n_t[0]);
  assign m3 = ~(&p);
  // complemented rails are supplied but these product terms need only K'
  logic unused_rails;
  assign unused_rails = ^n_c;
endmodule

// File: rtl/a3_bit2_dec.sv
module a3_bit2_dec
  import addsub3_pkg::*;
(
  input  logic [IDXW-1:0] idx,
  output logic            m2
);
  logic [3:0] bank_en;
  logic [LINES-1:0] line;

  a3_dec2to4 u_top (.en(1'b1), .sel(idx[4:3]), .y(bank_en));

  genvar g;
  generate
    for (g = 0; g < 4; g++) begin : g_bank
      a3_dec3to8 u_bank (.en(bank_en[g]), .sel(idx[2:0]), .y(line[8*g +: 8]));
    end
  endgenerate

  assign m2 = |(line & BIT2_LINES);

  always_comb begin
    if (!$isunknown(idx))
      a_r5_one_line: assert ($onehot(line)) else $error("R5 decoder lines not one-hot");
  end
endmodule

// File: rtl/a3_bit1_mux.sv
module a3_bit1_mux (
  input  logic [2:0] sel,
  input  logic [1:0] low,
  output logic       m1
);
  logic [7:0] d;
  genvar i;
  generate
    for (i = 0; i < 8; i++) begin : g_d
      if (i < 4) begin : g_plus
        assign d[i] = ~(low[1] ^ low[0]);
      end else begin : g_minus
        assign d[i] = low[1] ^ low[0];
      end
    end
  endgenerate
  assign m1 = d[sel];
endmodule

// File: rtl/a3_bit0_bus.sv
module a3_bit0_bus (
  input  logic [1:0] low,
  output logic       m0
);
  logic [3:0] drv_en;
  logic [3:0] drv_val;

  a3_dec2to4 u_dec (.en(1'b1), .sel(low), .y(drv_en));

  genvar i;
  generate
    for (i = 0; i < 4; i++) begin : g_drv
      assign drv_val[i] = (i % 2 == 0) ? 1'b1 : 1'b0;
    end
  endgenerate

  // merged line: only the enabled driver contributes
  assign m0 = |(drv_en & drv_val);

  always_comb begin
    if (!$isunknown(low))
      a_r7_one_driver: assert ($onehot(drv_en)) else $error("R7 driver enables not one-hot");
  end
endmodule

// File: rtl/addsub3_unit.sv
module addsub3_unit
  import addsub3_pkg::*;
(
  input  logic [3:0] n_in,
  input  logic       sub_mode,
  output logic [3:0] sum_out,
  output logic [3:0] alt_out
);
  a3_operand_adder #(.W(OPW)) u_add (.a_in(n_in), .sub_mode(sub_mode), .sum(sum_out));

  a3_bit3_nand u_b3 (.k_t(sub_mode), .k_c(~sub_mode), .n_t(n_in), .n_c(~n_in), .m3(alt_out[3]));
  a3_bit2_dec  u_b2 (.idx({sub_mode, n_in}), .m2(alt_out[2]));
  a3_bit1_mux  u_b1 (.sel({sub_mode, n_in[3:2]}), .low(n_in[1:0]), .m1(alt_out[1]));
  a3_bit0_bus  u_b0 (.low(n_in[1:0]), .m0(alt_out[0]));

  logic legal;
  assign legal = sub_mode ? (n_in >= 4'd3) : (n_in <= 4'd12);

  always_comb begin
    if (!$isunknown({sub_mode, n_in}) && legal) begin
      a_r4_top_bit: assert (alt_out[3] == sum_out[3]) else $error("R4 bit3 mismatch");
      a_r5_bit2: assert (alt_out[2] == sum_out[2]) else $error("R5 bit2 mismatch");
      a_r6_bit1: assert (alt_out[1] == sum_out[1]) else $error("R6 bit1 mismatch");
      a_r7_bit0: assert (alt_out[0] == sum_out[0]) else $error("R7 bit0 mismatch");
      a_r8_lsb_flip: assert (sum_out[0] != n_in[0]) else $error("R8 low bit not flipped");
    end
  end
endmodule

// File: tb/addsub3_unit_test.sv
module addsub3_unit_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0] n_in = 4'd0;
  logic sub_mode = 1'b0;
  logic [3:0] sum_out, alt_out;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  addsub3_unit uut (.n_in(n_in), .sub_mode(sub_mode), .sum_out(sum_out), .alt_out(alt_out));

  function automatic logic [3:0] expect_m(input logic [3:0] n, input logic k);
    int v;
    v = k ? int'(n) - 3 : int'(n) + 3;
    return 4'(v);
  endfunction

  task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp_v);
    checks++;
    if (act !== exp_v) begin
      errors++;
      $display("FAIL %s n=%0d k=%0b actual=%b expected=%b", tag, n_in, sub_mode, act, exp_v);
    end
  endtask

  task automatic apply(input logic [3:0] n, input logic k);
    logic [3:0] e;
    @(posedge clk);
    n_in = n; sub_mode = k;
    @(negedge clk);
    e = expect_m(n, k);
    chk(k ? "R2 sum" : "R1 sum", sum_out, e);
    chk("R4 alt bit3", {3'b0, alt_out[3]}, {3'b0, e[3]});
    chk("R5 alt bit2", {3'b0, alt_out[2]}, {3'b0, e[2]});
    chk("R6 alt bit1", {3'b0, alt_out[1]}, {3'b0, e[1]});
    chk("R7 alt bit0", {3'b0, alt_out[0]}, {3'b0, e[0]});
    chk("R8 low flip", {3'b0, sum_out[0]}, {3'b0, ~n[0]});
  endtask

  initial begin
    void'($urandom(32'd2024));
    repeat (2) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 initial", sum_out, 4'd3);
    // R3: change inputs without waiting for a clock edge
    n_in = 4'd9; sub_mode = 1'b1;
    #1;
    chk("R3 no clock", sum_out, 4'd6);
    chk("R3 alt no clock", alt_out, 4'd6);
    // directed corners
    apply(4'd0, 1'b0);  apply(4'd12, 1'b0);
    apply(4'd3, 1'b1);  apply(4'd15, 1'b1);
    apply(4'd4, 1'b0);  apply(4'd7, 1'b0);
    apply(4'd8, 1'b1);  apply(4'd11, 1'b1);
    // full legal sweep, index {k,n}
    for (int idx = 0; idx < 32; idx++) begin
      logic k;
      logic [3:0] n;
      k = idx[4]; n = idx[3:0];
      if (k ? (n >= 3) : (n <= 12)) apply(n, k);
    end
    // random legal pairs
    for (int r = 0; r < 200; r++) begin
      logic k;
      logic [3:0] n;
      k = 1'($urandom);
      n = k ? 4'(3 + ($urandom % 13)) : 4'($urandom % 13);
      apply(n, k);
    end
    done = 1'b1;
  end

  initial begin
    fork
      begin wait (done); end
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule